// File: doc/BRIEF.md
# Six-Pin GPIO Port with Sleep Wake-on-Change

This block is the general-purpose I/O port of a small 8-bit microcontroller. It holds an output latch, a direction register that software can only write, and the global control bits for weak pull-ups, pin-change wake-up and the timer clock source. Pin inputs pass through a two-flop synchronizer before they are read back or compared. The port data register reads as the synchronized pin levels, zero-extended to the data width. Every read or write of that register copies the synchronized levels into a reference snapshot.

While the core sleeps, the block compares a fixed subset of pins (GP0, GP1 and GP3) against the snapshot. Any difference raises a sticky wake request toward the reset circuitry. Each pin's direction bit takes priority over the global features. A pin set as an output gets no pull-up and takes no part in wake-up. When the timer clock source is selected, GP2 is forced to an input. GP3 can never drive. A wake flag records whether the most recent reset came from a pin-change wake.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset, `pin_oe_o` and `pin_pu_o` are all zero, `wake_req_o` and `wake_flag_o` are 0, and `rdata_o[7:6]` reads 0.
- R2: A pulse on `port_wr_i` stores `wdata_i[5:0]` into the output latch, which appears on `pin_out_o` from the next cycle. Writing `wdata_i[5:0]` with `dir_we_i` sets the direction, where 0 means output. `pin_oe_o[i]` is the inverse of direction bit i, apart from the overrides in R3 and R4.
- R3: `pin_oe_o[3]` (GP3) is never 1, whatever the direction bit.
- R4: While the timer-source bit (`wdata_i[5]` of a `ctl_we_i` write, reset value 1) is 1, `pin_oe_o[2]` is 0 even when direction bit 2 is 0.
- R5: `rdata_o` equals the pin levels delayed by two clock stages, zero-extended to 8 bits. Bits 7 and 6 always read 0.
- R6: `pin_pu_o[i]` is 1 exactly when the pull-up disable bit (`wdata_i[6]` of a `ctl_we_i` write, active low, reset value 1) is 0 and direction bit i is 1.
- R7: While `sleep_i` is 1, the wake-disable bit (`wdata_i[7]` of a `ctl_we_i` write, active low, reset value 1) is 0, and a synchronized level on GP0, GP1 or GP3 differs from the snapshot on a pin whose direction bit is 1, `wake_req_o` rises and stays high until `sleep_i` falls.
- R8: Changes on GP2, GP4 and GP5, changes on pins whose direction bit is 0, and any change while the wake-disable bit is 1, do not raise `wake_req_o`.
- R9: A pulse on either `port_rd_i` or `port_wr_i` copies the synchronized pin levels into the wake-compare snapshot.
- R10: `wake_flag_o` changes only during reset. It reads 1 after a reset taken with `rst_wake_i` = 1, and 0 after any other reset.
- R11: Any reset returns every direction bit to 1, so all output enables drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| rst_wake_i | input | 1 | Marks the current reset as a pin-change wake |
| wdata_i | input | 8 | Write data for port, direction and control writes |
| port_wr_i | input | 1 | Port data register write strobe |
| port_rd_i | input | 1 | Port data register read strobe |
| dir_we_i | input | 1 | Direction register load strobe |
| ctl_we_i | input | 1 | Control bits load (bit7 wake disable, bit6 pull-up disable, bit5 timer source) |
| sleep_i | input | 1 | Core is sleeping |
| pin_i | input | 6 | Pad input levels |
| rdata_o | output | 8 | Port readback |
| pin_oe_o | output | 6 | Per-pin output enable |
| pin_out_o | output | 6 | Per-pin output value |
| pin_pu_o | output | 6 | Per-pin weak pull-up enable |
| wake_req_o | output | 1 | Wake request to the reset circuitry |
| wake_flag_o | output | 1 | Last reset was a pin-change wake |

## Verification
The hardest case to reach is a wake decision that depends on which access last refreshed the snapshot. Pins can only be compared once the core is asleep, and no access can happen during sleep. To test this, the stimulus first settles the pins and issues a port access while awake. It then changes the pins and refreshes the snapshot with a different kind of access, and only then enters sleep. The result shows whether the second access replaced the reference. The same setup is repeated with each disqualifying condition in turn: an excluded pin, an output-direction pin, and wake-up disabled. Each variant must show no request, which separates a missing override from a missing detection.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
    // Bit positions of the control fields inside wdata_i on a control write.
    localparam int CTL_WAKE_N_BIT = 7;
    localparam int CTL_PU_N_BIT   = 6;
    localparam int CTL_TSEL_BIT   = 5;
    localparam int SYNC_STAGES    = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i) stage_q[s] <= d_i;
            end else begin : g_rest
                always_ff @(posedge clk_i) stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_wake_detect.sv
module gpio_wake_detect #(
    parameter int W = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         sleep_i,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] ref_i,
    input  logic [W-1:0] elig_i,
    output logic         req_o
);
    logic req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (!rst_ni || !sleep_i) begin
            req_d = 1'b0;
        end else if (|((cur_i ^ ref_i) & elig_i)) begin
            req_d = 1'b1;
        end
    end

    always_ff @(posedge clk_i) req_q <= req_d;

    assign req_o = req_q;

    // R7: a request can only start while the core sleeps
    p_req_starts_asleep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_q) |-> $past(sleep_i));
    // R7: a request holds for as long as sleep lasts
    p_req_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_q && sleep_i) |=> req_q);
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
    import gpio_wake_pkg::*;
#(
    parameter int              NPINS       = 6,
    parameter int              DATA_W      = 8,
    parameter int              IN_ONLY_IDX = 3,
    parameter int              TCLK_IDX    = 2,
    parameter logic [NPINS-1:0] WAKE_MASK  = 6'b001011
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rst_wake_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              port_wr_i,
    input  logic              port_rd_i,
    input  logic              dir_we_i,
    input  logic              ctl_we_i,
    input  logic              sleep_i,
    input  logic [NPINS-1:0]  pin_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NPINS-1:0]  pin_oe_o,
    output logic [NPINS-1:0]  pin_out_o,
    output logic [NPINS-1:0]  pin_pu_o,
    output logic              wake_req_o,
    output logic              wake_flag_o
);
    localparam logic [NPINS-1:0] ALL_IN = '1;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] out;
        logic [NPINS-1:0] snap;
        logic             wake_n;
        logic             pu_n;
        logic             tsel;
        logic             flag;
    } state_t;

    state_t st_d, st_q;
    logic [NPINS-1:0] pin_s;
    logic [NPINS-1:0] wake_elig;

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_ni) begin
            st_d.dir    = ALL_IN;
            st_d.out    = '0;
            st_d.snap   = '0;
            st_d.wake_n = 1'b1;
            st_d.pu_n   = 1'b1;
            st_d.tsel   = 1'b1;
            st_d.flag   = rst_wake_i;
        end else begin
            if (port_wr_i) st_d.out = wdata_i[NPINS-1:0];
            if (dir_we_i)  st_d.dir = wdata_i[NPINS-1:0];
            if (ctl_we_i) begin
                st_d.wake_n = wdata_i[CTL_WAKE_N_BIT];
                st_d.pu_n   = wdata_i[CTL_PU_N_BIT];
                st_d.tsel   = wdata_i[CTL_TSEL_BIT];
            end
            if (port_wr_i || port_rd_i) st_d.snap = pin_s;
        end
    end

    always_ff @(posedge clk_i) st_q <= st_d;

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            pin_oe_o[i] = ~st_q.dir[i];
            if (i == IN_ONLY_IDX)           pin_oe_o[i] = 1'b0;
            if (i == TCLK_IDX && st_q.tsel) pin_oe_o[i] = 1'b0;
            pin_pu_o[i] = ~st_q.pu_n & st_q.dir[i];
        end
    end

    assign wake_elig   = WAKE_MASK & st_q.dir & {NPINS{~st_q.wake_n}};
    assign pin_out_o   = st_q.out;
    assign rdata_o     = DATA_W'(pin_s);
    assign wake_flag_o = st_q.flag;

    gpio_wake_detect #(.W(NPINS)) u_wake (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sleep_i (sleep_i),
        .cur_i   (pin_s),
        .ref_i   (st_q.snap),
        .elig_i  (wake_elig),
        .req_o   (wake_req_o)
    );

    // R3: writing output direction to the input-only pin never enables it
    p_in_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(dir_we_i && !wdata_i[IN_ONLY_IDX]) |-> !pin_oe_o[IN_ONLY_IDX]);
    // R4: timer-source selection keeps its pin an input
    p_tclk_input_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(ctl_we_i && wdata_i[CTL_TSEL_BIT]) |-> !pin_oe_o[TCLK_IDX]);
    // R6: a pulled-up pin is never driven
    p_pu_not_driven_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_pu_o & pin_oe_o) == '0);
    // R10: the wake flag moves only during reset
    p_flag_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> $stable(wake_flag_o));
    // R11: leaving reset, no pin drives
    p_dir_reset_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |-> pin_oe_o == '0);
endmodule

// File: tb/gpio_wake_port_tb.sv
`timescale 1ns/1ps
module gpio_wake_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_wake = 1'b0;
    logic [7:0] wdata = '0;
    logic       port_wr = 1'b0, port_rd = 1'b0, dir_we = 1'b0, ctl_we = 1'b0;
    logic       sleep = 1'b0;
    logic [5:0] pins = '0;
    logic [7:0] rdata;
    logic [5:0] oe, outv, pu;
    logic       wreq, wflag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gpio_wake_port dut_i (
        .clk_i(clk), .rst_ni(rst_n), .rst_wake_i(rst_wake), .wdata_i(wdata),
        .port_wr_i(port_wr), .port_rd_i(port_rd), .dir_we_i(dir_we), .ctl_we_i(ctl_we),
        .sleep_i(sleep), .pin_i(pins), .rdata_o(rdata), .pin_oe_o(oe),
        .pin_out_o(outv), .pin_pu_o(pu), .wake_req_o(wreq), .wake_flag_o(wflag)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic wake);
        rst_n = 1'b0; rst_wake = wake; sleep = 1'b0;
        step(2);
        rst_n = 1'b1; rst_wake = 1'b0;
        step(1);
    endtask

    task automatic wr_dir(input logic [5:0] v);
        wdata = {2'b00, v}; dir_we = 1'b1; step(1); dir_we = 1'b0;
    endtask

    // wake_n, pu_n, tsel
    task automatic wr_ctl(input logic wn, input logic pn, input logic ts);
        wdata = {wn, pn, ts, 5'b0}; ctl_we = 1'b1; step(1); ctl_we = 1'b0;
    endtask

    task automatic wr_port(input logic [7:0] v);
        wdata = v; port_wr = 1'b1; step(1); port_wr = 1'b0;
    endtask

    task automatic rd_port();
        port_rd = 1'b1; step(1); port_rd = 1'b0;
    endtask

    task automatic t_reset();
        pins = 6'h3F; do_reset(1'b0); step(2);
        check("R1 oe", {2'b0, oe}, 8'h00);
        check("R1 pu", {2'b0, pu}, 8'h00);
        check("R1 req/flag", {6'b0, wreq, wflag}, 8'h00);
        check("R1 rdata top bits", {6'b0, rdata[7:6]}, 8'h00);
    endtask

    task automatic t_output();
        do_reset(1'b0);
        wr_ctl(1, 1, 0);
        wr_dir(6'b000000);
        wr_port(8'h35);
        check("R2 out latch", {2'b0, outv}, 8'h35);
        check("R2 oe all out", {2'b0, oe}, 8'h37);
        wr_dir(6'b101010);
        check("R2 oe pattern", {2'b0, oe}, 8'h15);
    endtask

    task automatic t_in_only();
        do_reset(1'b0);
        wr_ctl(1, 1, 0);
        wr_dir(6'b110111);
        check("R3 gp3 no drive", {2'b0, oe}, 8'h00);
    endtask

    task automatic t_tclk();
        do_reset(1'b0);
        wr_dir(6'b000000);
        check("R4 tsel reset forces gp2 in", {2'b0, oe}, 8'h33);
        wr_ctl(1, 1, 0);
        check("R4 tsel clear", {2'b0, oe}, 8'h37);
        wr_ctl(1, 1, 1);
        check("R4 tsel set", {2'b0, oe}, 8'h33);
    endtask

    task automatic t_readback();
        pins = 6'b101101; step(3);
        check("R5 readback", rdata, 8'h2D);
        pins = 6'b010010; step(3);
        check("R5 readback 2", rdata, 8'h12);
    endtask

    task automatic t_pullup();
        do_reset(1'b0);
        wr_ctl(1, 0, 1);
        wr_dir(6'b110000);
        check("R6 pu on inputs", {2'b0, pu}, 8'h30);
        wr_ctl(1, 1, 1);
        check("R6 pu disabled", {2'b0, pu}, 8'h00);
    endtask

    task automatic t_wake();
        do_reset(1'b0);
        wr_ctl(0, 1, 1);
        pins = 6'b000000; step(3); rd_port();
        sleep = 1'b1; step(3);
        check("R7 no change no req", {7'b0, wreq}, 8'h00);
        pins = 6'b000010; step(4);
        check("R7 gp1 wakes", {7'b0, wreq}, 8'h01);
        pins = 6'b000000; step(3);
        check("R7 req sticky", {7'b0, wreq}, 8'h01);
        do_reset(1'b1);
        check("R10 flag after wake reset", {7'b0, wflag}, 8'h01);
        do_reset(1'b0);
        check("R10 flag after other reset", {7'b0, wflag}, 8'h00);
    endtask

    task automatic t_wake_ignored();
        do_reset(1'b0);
        wr_ctl(0, 1, 1);
        pins = 6'b000000; step(3); rd_port();
        sleep = 1'b1;
        pins = 6'b110100; step(4);
        check("R8 gp2/4/5 ignored", {7'b0, wreq}, 8'h00);
        sleep = 1'b0; pins = 6'b000000; step(3);
        wr_dir(6'b110111); rd_port();
        sleep = 1'b1; pins = 6'b001000; step(4);
        check("R8 output pin ignored", {7'b0, wreq}, 8'h00);
        sleep = 1'b0; pins = 6'b000000; step(3);
        wr_dir(6'b111111); wr_ctl(1, 1, 1); rd_port();
        sleep = 1'b1; pins = 6'b000001; step(4);
        check("R8 wake disabled", {7'b0, wreq}, 8'h00);
        sleep = 1'b0; step(1);
    endtask

    task automatic t_snapshot();
        do_reset(1'b0);
        wr_ctl(0, 1, 1);
        pins = 6'b000000; step(3); rd_port();
        pins = 6'b000001; step(3); wr_port(8'h00);
        sleep = 1'b1; step(4);
        check("R9 write refreshes snapshot", {7'b0, wreq}, 8'h00);
        sleep = 1'b0; pins = 6'b000000; step(3);
        sleep = 1'b1; step(4);
        check("R9 no access keeps snapshot", {7'b0, wreq}, 8'h01);
        sleep = 1'b0; step(1);
        check("R7 req drops on wake", {7'b0, wreq}, 8'h00);
    endtask

    task automatic t_dir_reset();
        do_reset(1'b0);
        wr_ctl(1, 1, 0);
        wr_dir(6'b000000);
        check("R11 drive before reset", {2'b0, oe}, 8'h37);
        do_reset(1'b0);
        check("R11 drive after reset", {2'b0, oe}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_output();
        t_in_only();
        t_tclk();
        t_readback();
        t_pullup();
        t_wake();
        t_wake_ignored();
        t_snapshot();
        t_dir_reset();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule